// File: doc/BRIEF.md
# Open-Bus Read Data Decoder

This block sits on the data side of an 8-bit processor bus with a 16-bit address. In every cycle it decodes the address and picks the byte that a read returns. Three external regions each have a data byte and a valid flag from the outside. The window from $6000 to $7FFF can hold a small internal work RAM. That RAM is fitted only when a parameter asks for it, and it answers only while a software-controlled enable bit is set.

When nothing answers a read, the block does not return a constant. It returns the byte that last crossed the bus, which imitates the charge left on an undriven data bus. This holds for an unfitted or gated-off window, for a region whose valid flag is low, and for idle cycles. A held byte of $60 left by a jump operand or a stack pull can therefore be fetched again from an unmapped address. A surrounding core uses the block by driving address and strobes and taking `rdata` in the same cycle.

Top module: `obus_decoder`

## Requirements
- R1: A read decodes the top three address bits. Values 000 select region 0, 001 and 010 select region 1, and 1xx selects region 2. Region i returns `extData[8*i+7:8*i]` when `extValid[i]` is 1. `rdata` is valid in the same cycle as the read strobe.
- R2: A read of a region whose `extValid` bit is 0 returns the retained bus byte.
- R3: A read in the window (top bits 011) while the RAM is fitted and enabled returns the RAM byte at `addr[RAM_AW-1:0]`. The window mirrors the RAM, so $6020 and $6120 hold the same byte when RAM_AW is 8.
- R4: A read in the window while the RAM is disabled returns the retained bus byte.
- R5: A write in the window while the RAM is enabled stores `wdata`. A write while the RAM is disabled leaves the contents unchanged.
- R6: At the clock edge that ends a write cycle, the retained byte loads `wdata`. At the edge that ends a read cycle, it loads the byte just returned, so a read that falls on open bus leaves it unchanged. Idle cycles and control writes leave it unchanged.
- R7: When `ctlWr` is 1, the RAM enable loads `ctlData` at the clock edge. The synchronous reset sets the enable to EN_INIT and clears the retained byte to 0.
- R8: While `rd` is 0, `rdata` shows the retained byte.
- R9: When `rd` and `wr` are both 1, the cycle is a write only. `rdata` shows the retained byte and `wdata` is captured.
- R10: With RAM_PRESENT = 0, no storage exists, and every window read returns the retained byte whatever the enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| ctlWr | input | 1 | Load strobe for the RAM enable |
| ctlData | input | 1 | New RAM enable value |
| extData | input | 24 | Data bytes of regions 2..0 |
| extValid | input | 3 | Per-region answer flags |
| rdata | output | 8 | Read data |

## Verification
Read data is combinational, so every returned byte is due in the cycle of the strobe itself. The bench drives its inputs just after a falling edge and samples half a nanosecond later, before the rising edge. The retained byte and the RAM enable change only at the rising edge that ends a cycle, so their effect is checked one stimulus step later. The bench does this either through an open-bus read or through an idle cycle that exposes the held byte on `rdata`.

// File: rtl/obus_pkg.sv
package obus_pkg;
  localparam int NUM_EXT = 3;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic               ramRead;
    logic               ramWrite;
    logic [NUM_EXT-1:0] extSel;
    logic               capRead;
    logic               capWrite;
  } busStrobe_t;
endpackage

// File: rtl/obus_ctrl.sv
module obus_ctrl
  import obus_pkg::*;
#(
  parameter bit RAM_PRESENT = 1'b1,
  parameter bit EN_INIT     = 1'b0,
  parameter int ADDR_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic               ctlWr,
  input  logic               ctlData,
  input  logic [NUM_EXT-1:0] extValid,
  output logic               ramEn,
  output busStrobe_t         strb
);
  logic [2:0]         topBits;
  logic [1:0]         regionIdx;
  logic               rdEff;
  logic               inWin;
  logic               ramOk;
  logic [NUM_EXT-1:0] extSelV;

  assign topBits = addr[ADDR_W-1 -: 3];
  assign rdEff   = rd & ~wr;
  assign inWin   = (topBits == 3'b011);
  assign ramOk   = RAM_PRESENT & ramEn;

  always_comb begin
    if (topBits[2])            regionIdx = 2'd2;
    else if (topBits == 3'b000) regionIdx = 2'd0;
    else                       regionIdx = 2'd1;
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_sel
    assign extSelV[i] = rdEff & ~inWin & (regionIdx == 2'(i)) & extValid[i];
  end

  always_comb begin
    strb.ramRead  = rdEff & inWin & ramOk;
    strb.ramWrite = wr & inWin & ramOk;
    strb.extSel   = extSelV;
    strb.capRead  = rdEff;
    strb.capWrite = wr;
  end

  always_ff @(posedge clk) begin
    if (rst)        ramEn <= EN_INIT;
    else if (ctlWr) ramEn <= ctlData;
  end
endmodule

// File: rtl/obus_datapath.sv
module obus_datapath
  import obus_pkg::*;
#(
  parameter bit RAM_PRESENT = 1'b1,
  parameter int RAM_AW      = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [RAM_AW-1:0]         ramIdx,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic [NUM_EXT*BYTE_W-1:0] extData,
  input  busStrobe_t                strb,
  output logic [BYTE_W-1:0]         rdata
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [BYTE_W-1:0] lastByte;
  logic [BYTE_W-1:0] ramQ;
  logic [BYTE_W-1:0] extQ;

  if (RAM_PRESENT) begin : g_ram
    logic [BYTE_W-1:0] mem [RAM_DEPTH];
    always_ff @(posedge clk) begin
      if (strb.ramWrite) mem[ramIdx] <= wdata;
    end
    assign ramQ = mem[ramIdx];
  end else begin : g_noram
    logic unusedIdx;
    assign unusedIdx = ^{ramIdx, strb.ramWrite};
    assign ramQ = '0;
  end

  always_comb begin
    extQ = '0;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (strb.extSel[i]) extQ = extQ | extData[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    if (strb.ramRead)      rdata = ramQ;
    else if (|strb.extSel) rdata = extQ;
    else                   rdata = lastByte;
  end

  always_ff @(posedge clk) begin
    if (rst)                lastByte <= '0;
    else if (strb.capWrite) lastByte <= wdata;
    else if (strb.capRead)  lastByte <= rdata;
  end
endmodule

// File: rtl/obus_decoder.sv
module obus_decoder
  import obus_pkg::*;
#(
  parameter bit RAM_PRESENT = 1'b1,
  parameter bit EN_INIT     = 1'b0,
  parameter int RAM_AW      = 8,
  parameter int ADDR_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic                      ctlWr,
  input  logic                      ctlData,
  input  logic [NUM_EXT*BYTE_W-1:0] extData,
  input  logic [NUM_EXT-1:0]        extValid,
  output logic [BYTE_W-1:0]         rdata
);
  busStrobe_t strb;
  logic       ramEn;

  obus_ctrl #(
    .RAM_PRESENT(RAM_PRESENT),
    .EN_INIT    (EN_INIT),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .rd      (rd),
    .wr      (wr),
    .ctlWr   (ctlWr),
    .ctlData (ctlData),
    .extValid(extValid),
    .ramEn   (ramEn),
    .strb    (strb)
  );

  obus_datapath #(
    .RAM_PRESENT(RAM_PRESENT),
    .RAM_AW     (RAM_AW)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ramIdx (addr[RAM_AW-1:0]),
    .wdata  (wdata),
    .extData(extData),
    .strb   (strb),
    .rdata  (rdata)
  );
endmodule

// File: rtl/obus_decoder_chk.sv
module obus_decoder_chk
  import obus_pkg::*;
#(
  parameter bit RAM_PRESENT = 1'b1,
  parameter bit EN_INIT     = 1'b0,
  parameter int ADDR_W      = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd,
  input logic               wr,
  input logic [BYTE_W-1:0]  wdata,
  input logic               ctlWr,
  input logic               ctlData,
  input logic [NUM_EXT-1:0] extValid,
  input logic [BYTE_W-1:0]  rdata,
  input logic               ramEn
);
  logic inWin;
  assign inWin = (addr[ADDR_W-1 -: 3] == 3'b011);

  a_r6_write_capture: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rd || rdata == $past(wdata)));

  a_r6_read_capture: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |=> (rd || rdata == $past(rdata)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd && !wr) |=> (rd || $stable(rdata)));

  a_r2_invalid_open: assert property (@(posedge clk) disable iff (rst)
    (!rd && !wr) ##1 (rd && !wr && addr[ADDR_W-1] && !extValid[2]) |-> $stable(rdata));

  a_r4_window_open: assert property (@(posedge clk) disable iff (rst)
    (!rd && !wr) ##1 (rd && !wr && inWin && (!RAM_PRESENT || !ramEn)) |-> $stable(rdata));

  a_r7_ctl_load: assert property (@(posedge clk) disable iff (rst)
    ctlWr |=> (ramEn == $past(ctlData)));

  a_r7_reset_value: assert property (@(posedge clk)
    rst |=> (ramEn == EN_INIT));
endmodule

bind obus_decoder obus_decoder_chk #(
  .RAM_PRESENT(RAM_PRESENT),
  .EN_INIT    (EN_INIT),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .rd      (rd),
  .wr      (wr),
  .wdata   (wdata),
  .ctlWr   (ctlWr),
  .ctlData (ctlData),
  .extValid(extValid),
  .rdata   (rdata),
  .ramEn   (ramEn)
);

// File: tb/obus_decoder_tb.sv
`timescale 1ns/100ps
module obus_decoder_tb;
  typedef struct packed {
    logic [15:0] a;
    logic        r;
    logic        w;
    logic [7:0]  wd;
    logic        c;
    logic        cd;
    logic [2:0]  ev;
    logic [7:0]  eb;
    logic        chk;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  // Requirement numbers in the req field: R1 decode, R2 invalid region, R3 RAM read,
  // R4 gated window, R5 RAM write, R6 retained byte, R8 idle, R9 read+write.
  localparam vec_t VECS [NV] = '{
    '{16'hC000,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h4C,1'b1,8'h4C,8'd1},
    '{16'hC001,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h56,1'b1,8'h56,8'd1},
    '{16'hC002,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h60,1'b1,8'h60,8'd1},
    '{16'h6056,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h60,8'd4},
    '{16'h6056,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h60,8'd6},
    '{16'h0000,1'b0,1'b0,8'h00,1'b1,1'b1,3'b111,8'h00,1'b0,8'h00,8'd7},
    '{16'h6020,1'b0,1'b1,8'h5A,1'b0,1'b0,3'b111,8'h00,1'b0,8'h00,8'd5},
    '{16'h6020,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h5A,8'd3},
    '{16'h6120,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h5A,8'd3},
    '{16'h0000,1'b0,1'b0,8'h00,1'b1,1'b0,3'b111,8'h00,1'b0,8'h00,8'd7},
    '{16'h6020,1'b0,1'b1,8'hAA,1'b0,1'b0,3'b111,8'h00,1'b0,8'h00,8'd5},
    '{16'h6020,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'hAA,8'd4},
    '{16'h0100,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h55,1'b1,8'h55,8'd1},
    '{16'h0101,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h60,1'b1,8'h60,8'd6},
    '{16'h7FFF,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h60,8'd6},
    '{16'h2000,1'b1,1'b0,8'h00,1'b0,1'b0,3'b101,8'h99,1'b1,8'h60,8'd2},
    '{16'h8000,1'b1,1'b0,8'h00,1'b0,1'b0,3'b011,8'h99,1'b1,8'h60,8'd2},
    '{16'h3FFF,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'hB2,1'b1,8'hB2,8'd1},
    '{16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'hB2,8'd8},
    '{16'h0000,1'b0,1'b0,8'h00,1'b1,1'b1,3'b111,8'h00,1'b1,8'hB2,8'd6},
    '{16'h6020,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h5A,8'd5},
    '{16'h0000,1'b1,1'b1,8'h77,1'b0,1'b0,3'b111,8'h22,1'b1,8'h5A,8'd9},
    '{16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h77,8'd9},
    '{16'h0000,1'b0,1'b0,8'h00,1'b1,1'b0,3'b111,8'h00,1'b1,8'h77,8'd6},
    '{16'h6020,1'b1,1'b0,8'h00,1'b0,1'b0,3'b111,8'h00,1'b1,8'h77,8'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, ctlWr = 1'b0, ctlData = 1'b0;
  logic [7:0]  wdata = '0;
  logic [23:0] extData = '0;
  logic [2:0]  extValid = '0;
  logic [7:0]  rdata, rdataNr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  obus_decoder #(.RAM_PRESENT(1'b1), .EN_INIT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .ctlWr(ctlWr), .ctlData(ctlData), .extData(extData), .extValid(extValid),
    .rdata(rdata));

  obus_decoder #(.RAM_PRESENT(1'b0), .EN_INIT(1'b1)) u_noram (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .ctlWr(ctlWr), .ctlData(ctlData), .extData(extData), .extValid(extValid),
    .rdata(rdataNr));

  task automatic step(input logic [15:0] a, input logic r, input logic w,
                      input logic [7:0] wd, input logic c, input logic cd,
                      input logic [2:0] ev, input logic [7:0] eb);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = wd; ctlWr = c; ctlData = cd;
    extValid = ev; extData = {3{eb}};
    #0.5;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; rd = 1'b0; wr = 1'b0; ctlWr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    doReset();
    // R7 and R8: cleared retained byte after reset
    step(16'h0000, 0, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    check("R7 reset retained byte", rdata, 8'h00);
    // R7: enable starts at 0 so the window is open bus
    step(16'h6000, 1, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    check("R7 reset enable off", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].a, VECS[i].r, VECS[i].w, VECS[i].wd, VECS[i].c, VECS[i].cd,
           VECS[i].ev, VECS[i].eb);
      if (VECS[i].chk) check($sformatf("R%0d vector %0d", VECS[i].req, i), rdata, VECS[i].exp);
    end

    // R10: no RAM fitted, even with the enable set
    step(16'h0000, 0, 0, 8'h00, 1, 1, 3'b111, 8'h00);
    step(16'h6030, 0, 1, 8'h3E, 0, 0, 3'b111, 8'h00);
    step(16'h6030, 1, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    check("R10 window read after write", rdataNr, 8'h3E);
    check("R3 fitted RAM returns stored byte", rdata, 8'h3E);
    step(16'h0000, 1, 0, 8'h00, 0, 0, 3'b111, 8'h12);
    check("R10 region 0 read", rdataNr, 8'h12);
    step(16'h6030, 1, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    check("R10 window keeps bus byte", rdataNr, 8'h12);

    // R7: reset mid-run restores enable and clears retained byte
    doReset();
    step(16'h6030, 1, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    check("R7 enable back to init", rdata, 8'h00);
    check("R7 retained cleared on absent RAM", rdataNr, 8'h00);

    step(16'h0000, 0, 0, 8'h00, 0, 0, 3'b111, 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule